// File: doc/BRIEF.md
# VID Code Settle Filter and Transition Blanking

This block sits between the six voltage-identification inputs of a multiphase core regulator and its reference DAC. The inputs arrive from another clock domain and may change with skew between bits. The block resynchronises them and watches the result. After any bit changes, it holds back the new value until the inputs have stayed unchanged for a programmable settle time. Only then does it load the code into the register that feeds the DAC, and it pulses a strobe as it loads.

A supervisor uses the blanking flag to mask power-good and overvoltage-crowbar faults while the output voltage moves. The flag rises on the first code change and stays high for a programmable window. Every later change starts the window again, so a transition made of several up or down steps stays masked until the last step has had time to settle. A veto output tells the power-good logic to report low. It is high while the block is disabled or while the loaded code is all ones.

Top module: `vid_settle_blank`

## Requirements
- R1: While reset is held, `vid_code` is 0 and `code_vld` and `blank` are 0.
- R2: When enabled, a change of `vid_raw` that is then held steady appears on `vid_code` exactly HOLD_CYC+3 clock cycles after the change. Two of those cycles are input synchronisation and one is change detection.
- R3: `vid_code` changes only in a cycle where `code_vld` is high, and `code_vld` is a single-cycle pulse, one per load.
- R4: A further change during the settle time restarts it. Intermediate codes are never loaded, and the final code appears HOLD_CYC+3 cycles after the last change.
- R5: While enabled, a change of `vid_raw` raises `blank` 3 cycles later. Without further changes, `blank` stays high for exactly BLANK_CYC cycles.
- R6: Each change during an active blanking window restarts it. `blank` stays high without a gap and falls BLANK_CYC+3 cycles after the last change.
- R7: Upward and downward code steps are filtered and loaded identically, one load per settled step.
- R8: `pg_veto` is high whenever the loaded code is all ones (6'h3F at the default width).
- R9: While `en` is low, `pg_veto` is high at once, `blank` is 0 from the next cycle, no load occurs and `vid_code` keeps its value.
- R10: When `en` rises, the code present on `vid_raw` is loaded HOLD_CYC cycles later without raising `blank`. Changes made while disabled do not start blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Block enable (synchronous to clk) |
| vid_raw | input | VID_W | Unsynchronised identification code inputs |
| vid_code | output | VID_W | Settled code feeding the reference DAC |
| code_vld | output | 1 | One-cycle pulse when `vid_code` is loaded |
| blank | output | 1 | Power-good and crowbar fault masking window |
| pg_veto | output | 1 | Forces power-good low: disabled or all-ones code |

## Verification
Suppose the settle counter or the sampled-input register holds a wrong value. The `code_vld` pulse then arrives at the wrong cycle, or an intermediate skewed code is loaded. The scoreboard catches both on the first transition, because it compares the load cycle to the exact HOLD_CYC+3 latency. A corrupted blanking counter shows as `blank` falling earlier or later than BLANK_CYC+3 cycles after the last change. It can also show as a dip inside a retriggered window, which is checked on every cycle of a closely spaced multi-step sequence. A stuck state on the enable path shows as a load, or as `blank`, while disabled, within a few cycles.

// File: rtl/vid_pkg.sv
package vid_pkg;
  typedef enum logic {
    HO_IDLE   = 1'b0,
    HO_SETTLE = 1'b1
  } ho_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/vid_holdoff.sv
module vid_holdoff
  import vid_pkg::*;
#(
  parameter int W        = 6,
  parameter int HOLD_CYC = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] vid_s,
  output logic [W-1:0] vid_code,
  output logic         code_vld,
  output logic         chg_evt
);
  localparam int            CW       = cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

  ho_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  smp_q;
  logic [W-1:0]  code_q;
  logic          vld_q, vld_d;
  logic          chg;
  logic          load;

  assign chg = (vid_s != smp_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    load  = 1'b0;
    if (!en) begin
      st_d  = HO_SETTLE;
      cnt_d = '0;
    end else if (chg) begin
      st_d  = HO_SETTLE;
      cnt_d = '0;
    end else if (st_q == HO_SETTLE) begin
      if (cnt_q == CNT_LAST) begin
        st_d  = HO_IDLE;
        cnt_d = '0;
        vld_d = 1'b1;
        load  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HO_SETTLE;
      cnt_q <= '0;
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      smp_q <= vid_s;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load) begin
      code_q <= vid_s;
    end
  end

  assign vid_code = code_q;
  assign code_vld = vld_q;
  assign chg_evt  = en & chg;
endmodule

// File: rtl/vid_blank_timer.sv
module vid_blank_timer
  import vid_pkg::*;
#(
  parameter int BLANK_CYC = 31250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig,
  output logic blank
);
  localparam int            BW      = cnt_width(BLANK_CYC);
  localparam logic [BW-1:0] LD_LAST = BW'(BLANK_CYC - 1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          blk_q, blk_d;

  always_comb begin
    cnt_d = cnt_q;
    blk_d = blk_q;
    if (!en) begin
      cnt_d = '0;
      blk_d = 1'b0;
    end else if (trig) begin
      cnt_d = LD_LAST;
      blk_d = 1'b1;
    end else if (blk_q) begin
      if (cnt_q == '0) blk_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign blank = blk_q;
endmodule

// File: rtl/vid_settle_blank.sv
module vid_settle_blank #(
  parameter int VID_W     = 6,
  parameter int HOLD_CYC  = 50,
  parameter int BLANK_CYC = 31250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VID_W-1:0] vid_raw,
  output logic [VID_W-1:0] vid_code,
  output logic             code_vld,
  output logic             blank,
  output logic             pg_veto
);
  logic             rst_meta_q, rst_sync_q;
  logic [VID_W-1:0] vid_s;
  logic             chg_evt;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  vid_sync #(.W(VID_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (vid_raw),
    .q     (vid_s)
  );

  vid_holdoff #(.W(VID_W), .HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .en       (en),
    .vid_s    (vid_s),
    .vid_code (vid_code),
    .code_vld (code_vld),
    .chg_evt  (chg_evt)
  );

  vid_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .en    (en),
    .trig  (chg_evt),
    .blank (blank)
  );

  assign pg_veto = ~en | (&vid_code);
endmodule

// File: rtl/vid_settle_blank_chk.sv
module vid_settle_blank_chk #(
  parameter int VID_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [VID_W-1:0] vid_code,
  input logic             code_vld,
  input logic             blank
);
  assert_code_moves_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vid_code) |-> code_vld);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |=> !code_vld);

  assert_no_load_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> $past(en));

  assert_blank_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !blank);

  assert_blank_rise_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank) |-> $past(en));
endmodule

bind vid_settle_blank vid_settle_blank_chk #(.VID_W(VID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .vid_code (vid_code),
  .code_vld (code_vld),
  .blank    (blank)
);

// File: tb/vid_settle_blank_test.sv
module vid_settle_blank_test;
  localparam int HOLD  = 8;
  localparam int BLANK = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [5:0] vid_raw;
  logic [5:0] vid_code;
  logic       code_vld, blank, pg_veto;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] code;
    int         at;
    string      req;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;
  logic [5:0] prev_code = '0;

  vid_settle_blank #(.VID_W(6), .HOLD_CYC(HOLD), .BLANK_CYC(BLANK)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .vid_raw(vid_raw),
    .vid_code(vid_code), .code_vld(code_vld), .blank(blank), .pg_veto(pg_veto)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (code_vld) begin
        if (exp_q.size() == 0) begin
          check("R3", "unexpected load code", int'(vid_code), -1);
        end else begin
          mon_e = exp_q.pop_front();
          check(mon_e.req, "loaded code", int'(vid_code), int'(mon_e.code));
          check(mon_e.req, "load cycle", cyc, mon_e.at);
        end
      end
      if (vid_code !== prev_code && !code_vld)
        check("R3", "code moved without strobe", int'(vid_code), int'(prev_code));
    end
    prev_code = vid_code;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drive(input logic [5:0] v, input int lat, input string req, output int n);
    n = cyc;
    vid_raw = v;
    exp_q.push_back('{code: v, at: n + lat, req: req});
  endtask

  task automatic blank_end(input int n, input string req);
    wait_to(n + 2 + BLANK);
    check(req, "blank before end", int'(blank), 1);
    @(negedge clk);
    check(req, "blank after end", int'(blank), 0);
  endtask

  task automatic step_hold_blank(input int span, input string req);
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      check(req, "blank held", int'(blank), 1);
    end
  endtask

  initial begin
    int n, n2;
    rst_n = 1'b0; en = 1'b0; vid_raw = '0;
    tick(3);
    check("R1", "reset code", int'(vid_code), 0);
    check("R1", "reset strobe", int'(code_vld), 0);
    check("R1", "reset blank", int'(blank), 0);
    check("R9", "veto while disabled", int'(pg_veto), 1);
    rst_n = 1'b1;
    tick(4);
    mon_on = 1'b1;

    // R10: enable loads present code, no blanking
    vid_raw = 6'h15;
    tick(4);
    n = cyc;
    en = 1'b1;
    exp_q.push_back('{code: 6'h15, at: n + HOLD, req: "R10"});
    for (int i = 0; i < HOLD + 3; i++) begin
      @(negedge clk);
      check("R10", "no blank on enable", int'(blank), 0);
    end
    check("R10", "veto clear", int'(pg_veto), 0);

    // R2 / R5: single step
    drive(6'h16, HOLD + 3, "R2", n);
    wait_to(n + 2);
    check("R5", "blank not yet", int'(blank), 0);
    @(negedge clk);
    check("R5", "blank raised", int'(blank), 1);
    blank_end(n, "R5");

    // R4: skewed bits, second change in settle time
    drive(6'h2A, 0, "R4", n);
    void'(exp_q.pop_back());
    tick(3);
    drive(6'h2B, HOLD + 3, "R4", n2);
    wait_to(n2 + 2 + HOLD);
    check("R4", "intermediate not loaded", int'(vid_code), 6'h16);
    blank_end(n2, "R6");
    tick(5);

    // R6 / R7: multi-step up then down, spaced below blanking window
    drive(6'h20, HOLD + 3, "R7", n);
    tick(4);
    check("R6", "blank up", int'(blank), 1);
    for (int k = 1; k < 4; k++) begin
      step_hold_blank(16, "R6");
      drive(6'h20 + 6'(k), HOLD + 3, "R7", n);
    end
    for (int k = 0; k < 3; k++) begin
      step_hold_blank(20, "R6");
      drive(6'h1F - 6'(k), HOLD + 3, "R7", n);
    end
    blank_end(n, "R6");
    check("R7", "final down code", int'(vid_code), 6'h1D);

    // R8: all-ones code
    drive(6'h3F, HOLD + 3, "R8", n);
    wait_to(n + 2 + HOLD);
    check("R8", "veto before load", int'(pg_veto), 0);
    @(negedge clk);
    check("R8", "veto all ones", int'(pg_veto), 1);
    tick(4);
    drive(6'h3E, HOLD + 3, "R8", n);
    wait_to(n + 4 + HOLD);
    check("R8", "veto released", int'(pg_veto), 0);
    check("R9", "blank active before disable", int'(blank), 1);

    // R9: disable during blanking
    en = 1'b0;
    #1;
    check("R9", "veto on disable", int'(pg_veto), 1);
    @(negedge clk);
    check("R9", "blank cleared", int'(blank), 0);
    vid_raw = 6'h07;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R9", "blank stays low", int'(blank), 0);
    end
    check("R9", "code held", int'(vid_code), 6'h3E);

    // R10: re-enable after change while disabled
    n = cyc;
    en = 1'b1;
    exp_q.push_back('{code: 6'h07, at: n + HOLD, req: "R10"});
    for (int i = 0; i < HOLD + 4; i++) begin
      @(negedge clk);
      check("R10", "no blank after re-enable", int'(blank), 0);
    end
    tick(4);
    check("R3", "all loads seen", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("R1", "watchdog expired", 1, 0);
      finish_run();
    end
  end
endmodule